// File: doc/BRIEF.md
# Data Rate and Power Control Register

This block holds the write-only rate-select register of a disk controller together with the control logic around it. A host write to the register loads a 2-bit data-rate code and a 3-bit write-precompensation code. The same write can also request a software reset of the controller and put the controller into manual low-power mode. A second register, the configuration-control register, can also set the data rate. The block keeps track of which of the two registers was written last and drives the rate that register holds.

The software reset comes out as a single-cycle pulse. The reset bit never stays set, and the pulse does not reload the stored fields. The low-power flag is set by a register write or by a mode-command request line. It is cleared by a software reset or by any host access to the controller's data register or status register. The clock gating that the flag drives lies outside this block. All outputs are registered, so each one changes on the clock edge after the input that causes the change.

Top module: `drc_rate_power`

## Requirements
- R1: A synchronous hardware reset (`rst` high at a clock edge) sets the outputs at that edge to rate = 2, precomp = 0, soft_rst = 0 and low_power = 0. This is the register value 0x02. `rst` has priority over every other input in the same cycle.
- R2: A rate-select write (`rsel_wr`) takes precomp from wr_data[4:2] and the rate code from wr_data[1:0]. Both appear on the outputs at the next clock edge.
- R3: A configuration write (`cfg_wr`) on its own takes the rate from wr_data[1:0] at the next edge and leaves precomp unchanged.
- R4: The rate output keeps the value from the most recent write to either register and holds it while neither register is written. When both registers are written in the same cycle, the rate-select value wins.
- R5: A rate-select write with wr_data[7] = 1 drives soft_rst high for exactly the following cycle. precomp and rate are loaded from that same write and are not reverted by the reset.
- R6: low_power becomes 1 at the next edge after a rate-select write with wr_data[6] = 1, or after `lp_req` is high. It then stays at 1 until an exit condition occurs.
- R7: low_power becomes 0 at the next edge after `data_acc`, `stat_acc` or a rate-select write with wr_data[7] = 1. An exit condition overrides an entry condition in the same cycle.
- R8: wr_data[5] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| rsel_wr | input | 1 | Write strobe for the rate-select register |
| cfg_wr | input | 1 | Write strobe for the configuration-control register |
| wr_data | input | 8 | Host write data |
| data_acc | input | 1 | Host access to the data register |
| stat_acc | input | 1 | Host access to the main status register |
| lp_req | input | 1 | Mode-command request to enter low power |
| rate | output | 2 | Effective data-rate code |
| precomp | output | 3 | Write-precompensation code |
| soft_rst | output | 1 | One-cycle software reset pulse |
| low_power | output | 1 | Manual low-power flag |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled on the rising edge and that `wr_data` is valid whenever either write strobe is high. No other handshake is assumed. Strobes may overlap in any combination, and the checks cover both-register writes and entry-versus-exit conflicts. The stimulus drives all inputs on the falling edge, so each one is settled long before it is sampled. Random strobes are kept sparse enough that low-power periods last several cycles, and directed cycles force the same-cycle conflicts explicitly.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int DATA_W = 8;
    localparam int RATE_W = 2;
    localparam int PC_W   = 3;

    localparam logic [DATA_W-1:0] HW_RESET_VAL = 8'h02;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [PC_W-1:0]   pc_t;

    // Field layout of the rate-select register, most significant bit first.
    typedef struct packed {
        logic  srst;
        logic  lpwr;
        logic  rsvd;
        pc_t   pc;
        rate_t rate;
    } rsel_fields_t;

    typedef enum logic {
        OWN_SEL = 1'b0,
        OWN_CFG = 1'b1
    } rate_owner_e;

    function automatic rsel_fields_t unpack_rsel(input logic [DATA_W-1:0] d);
        rsel_fields_t f;
        f = rsel_fields_t'(d);
        return f;
    endfunction

    function automatic rate_t reset_rate();
        rsel_fields_t f;
        f = unpack_rsel(HW_RESET_VAL);
        return f.rate;
    endfunction

    function automatic pc_t reset_pc();
        rsel_fields_t f;
        f = unpack_rsel(HW_RESET_VAL);
        return f.pc;
    endfunction

endpackage

// File: rtl/drc_field_reg.sv
module drc_field_reg
    import drc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  pc_t   pc_in,
    input  rate_t rate_in,
    output pc_t   pc_q,
    output rate_t rate_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= reset_pc();
            rate_q <= reset_rate();
        end else if (load) begin
            pc_q   <= pc_in;
            rate_q <= rate_in;
        end
    end

    p_pc_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (pc_q == $past(pc_in)));

    p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc_q));

endmodule

// File: rtl/drc_rate_arb.sv
module drc_rate_arb
    import drc_pkg::*;
#(
    parameter bit SEL_WINS_TIE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_wr,
    input  rate_t sel_rate,
    input  logic  cfg_wr,
    input  rate_t cfg_rate,
    output rate_t rate_eff
);

    rate_owner_e owner_q, owner_d;
    rate_t       cfg_q;
    rate_t       sel_q;

    generate
        if (SEL_WINS_TIE) begin : g_sel_tie
            always_comb begin
                owner_d = owner_q;
                if (sel_wr)      owner_d = OWN_SEL;
                else if (cfg_wr) owner_d = OWN_CFG;
            end
        end else begin : g_cfg_tie
            always_comb begin
                owner_d = owner_q;
                if (cfg_wr)      owner_d = OWN_CFG;
                else if (sel_wr) owner_d = OWN_SEL;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_SEL;
            sel_q   <= reset_rate();
            cfg_q   <= reset_rate();
        end else begin
            owner_q <= owner_d;
            if (sel_wr) sel_q <= sel_rate;
            if (cfg_wr) cfg_q <= cfg_rate;
        end
    end

    assign rate_eff = (owner_q == OWN_CFG) ? cfg_q : sel_q;

    p_cfg_rate_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !sel_wr) |=> (rate_eff == $past(cfg_rate)));

    p_rate_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr && !sel_wr) |=> $stable(rate_eff));

    generate
        if (SEL_WINS_TIE) begin : g_chk_sel
            p_sel_rate_r4: assert property (@(posedge clk) disable iff (rst)
                sel_wr |=> (rate_eff == $past(sel_rate)));
        end
    endgenerate

endmodule

// File: rtl/drc_power_ctl.sv
module drc_power_ctl
    import drc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_wr,
    input  rsel_fields_t fields,
    input  logic         data_acc,
    input  logic         stat_acc,
    input  logic         lp_req,
    output logic         soft_rst,
    output logic         low_power
);

    logic reset_req;
    logic lp_enter;
    logic lp_leave;

    assign reset_req = sel_wr & fields.srst;
    assign lp_enter  = (sel_wr & fields.lpwr) | lp_req;
    assign lp_leave  = reset_req | data_acc | stat_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst  <= 1'b0;
            low_power <= 1'b0;
        end else begin
            soft_rst <= reset_req;
            if (lp_leave)      low_power <= 1'b0;
            else if (lp_enter) low_power <= 1'b1;
        end
    end

    p_srst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && fields.srst) |=> soft_rst);

    p_srst_cause_r5: assert property (@(posedge clk) disable iff (rst)
        !(sel_wr && fields.srst) |=> !soft_rst);

    p_lp_enter_r6: assert property (@(posedge clk) disable iff (rst)
        ((lp_req || (sel_wr && fields.lpwr)) && !data_acc && !stat_acc
         && !(sel_wr && fields.srst)) |=> low_power);

    p_lp_leave_r7: assert property (@(posedge clk) disable iff (rst)
        (data_acc || stat_acc || (sel_wr && fields.srst)) |=> !low_power);

endmodule

// File: rtl/drc_rate_power.sv
module drc_rate_power
    import drc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rsel_wr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              data_acc,
    input  logic              stat_acc,
    input  logic              lp_req,
    output logic [RATE_W-1:0] rate,
    output logic [PC_W-1:0]   precomp,
    output logic              soft_rst,
    output logic              low_power
);

    rsel_fields_t fields;
    rate_t        sel_rate_q;
    pc_t          pc_q;
    rate_t        rate_eff;

    assign fields = unpack_rsel(wr_data);

    drc_field_reg u_fields (
        .clk     (clk),
        .rst     (rst),
        .load    (rsel_wr),
        .pc_in   (fields.pc),
        .rate_in (fields.rate),
        .pc_q    (pc_q),
        .rate_q  (sel_rate_q)
    );

    drc_rate_arb #(.SEL_WINS_TIE(1'b1)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (rsel_wr),
        .sel_rate (fields.rate),
        .cfg_wr   (cfg_wr),
        .cfg_rate (fields.rate),
        .rate_eff (rate_eff)
    );

    drc_power_ctl u_pwr (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (rsel_wr),
        .fields    (fields),
        .data_acc  (data_acc),
        .stat_acc  (stat_acc),
        .lp_req    (lp_req),
        .soft_rst  (soft_rst),
        .low_power (low_power)
    );

    assign rate    = rate_eff;
    assign precomp = pc_q;

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_state_r1: assert (rate == reset_rate() && precomp == reset_pc()
                                      && !soft_rst && !low_power);
        end
    end

    p_sel_rate_agree_r2: assert property (@(posedge clk) disable iff (rst)
        rsel_wr |=> (rate == sel_rate_q));

endmodule

// File: tb/test_drc_rate_power.sv
`timescale 1ns/1ps
module test_drc_rate_power;

    logic       clk = 1'b0;
    logic       rst;
    logic       rsel_wr, cfg_wr, data_acc, stat_acc, lp_req;
    logic [7:0] wr_data;
    logic [1:0] rate;
    logic [2:0] precomp;
    logic       soft_rst, low_power;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the requirements
    int m_rate, m_pc, m_srst, m_lp;

    always #2 clk = ~clk;

    drc_rate_power i_drc_rate_power (
        .clk(clk), .rst(rst), .rsel_wr(rsel_wr), .cfg_wr(cfg_wr),
        .wr_data(wr_data), .data_acc(data_acc), .stat_acc(stat_acc),
        .lp_req(lp_req), .rate(rate), .precomp(precomp),
        .soft_rst(soft_rst), .low_power(low_power)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_lp(input int lp, input bit rs, input bit sw,
                                   input logic [7:0] d, input bit da,
                                   input bit sa, input bit lq);
        bit leave, enter;
        leave = (sw && d[7]) || da || sa;
        enter = (sw && d[6]) || lq;
        if (rs)    return 0;
        if (leave) return 0;
        if (enter) return 1;
        return lp;
    endfunction

    function automatic int next_rate(input int r, input bit rs, input bit sw,
                                     input bit cw, input logic [7:0] d);
        if (rs) return 2;
        if (sw) return int'(d[1:0]);
        if (cw) return int'(d[1:0]);
        return r;
    endfunction

    // Apply one cycle of stimulus, advance the model, compare after the edge.
    task automatic step(input bit rs, input bit sw, input bit cw,
                        input logic [7:0] d, input bit da, input bit sa,
                        input bit lq, input string tag);
        rst = rs; rsel_wr = sw; cfg_wr = cw; wr_data = d;
        data_acc = da; stat_acc = sa; lp_req = lq;
        m_lp   = next_lp(m_lp, rs, sw, d, da, sa, lq);
        m_rate = next_rate(m_rate, rs, sw, cw, d);
        m_pc   = rs ? 0 : (sw ? int'(d[4:2]) : m_pc);
        m_srst = (!rs && sw && d[7]) ? 1 : 0;
        @(negedge clk);
        chk({tag, " rate"},      int'(rate),      m_rate);
        chk({tag, " precomp"},   int'(precomp),   m_pc);
        chk({tag, " soft_rst"},  int'(soft_rst),  m_srst);
        chk({tag, " low_power"}, int'(low_power), m_lp);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_rate = 0; m_pc = 0; m_srst = 0; m_lp = 0;
        @(negedge clk);
        step(1, 0, 0, 8'h00, 0, 0, 0, "R1 reset");
        chk("R1 reset rate const", int'(rate), 2);
        step(1, 0, 0, 8'h00, 0, 0, 0, "R1 reset hold");

        step(0, 1, 0, 8'h1F, 0, 0, 0, "R2 load 0x1F");
        chk("R2 precomp const", int'(precomp), 7);
        step(0, 0, 1, 8'h01, 0, 0, 0, "R3 cfg rate");
        chk("R3 precomp kept", int'(precomp), 7);
        chk("R3 rate const", int'(rate), 1);
        idle("R4 hold");
        step(0, 1, 0, 8'h0A, 0, 0, 0, "R4 sel after cfg");
        step(0, 1, 1, 8'h03, 0, 0, 0, "R4 same cycle");
        chk("R4 tie rate const", int'(rate), 3);

        step(0, 1, 0, 8'h9D, 0, 0, 0, "R5 reset write");
        chk("R5 pulse const", int'(soft_rst), 1);
        idle("R5 pulse ends");
        chk("R5 fields kept", int'(precomp), 7);

        step(0, 1, 0, 8'h40, 0, 0, 0, "R6 lp write");
        idle("R6 lp holds");
        chk("R6 lp const", int'(low_power), 1);
        step(0, 0, 0, 8'h00, 1, 0, 0, "R7 data access exit");
        step(0, 0, 0, 8'h00, 0, 0, 1, "R6 lp request");
        step(0, 0, 0, 8'h00, 0, 1, 0, "R7 status access exit");
        step(0, 1, 0, 8'h40, 1, 0, 0, "R7 exit beats entry");
        chk("R7 conflict const", int'(low_power), 0);
        step(0, 0, 0, 8'h00, 0, 0, 1, "R6 lp request again");
        step(0, 1, 0, 8'hC0, 0, 0, 0, "R7 soft reset exit");

        step(0, 1, 0, 8'h20, 0, 0, 0, "R8 reserved bit");
        chk("R8 lp const", int'(low_power), 0);
        chk("R8 srst const", int'(soft_rst), 0);
        chk("R8 rate const", int'(rate), 0);
        step(0, 1, 0, 8'h3F, 0, 0, 0, "R8 reserved with fields");

        step(1, 1, 1, 8'hDF, 0, 0, 1, "R1 reset priority");

        for (int i = 0; i < 4000; i++) begin
            bit rs, sw, cw, da, sa, lq;
            logic [7:0] d;
            rs = ($urandom_range(0, 199) == 0);
            sw = ($urandom_range(0, 3) == 0);
            cw = ($urandom_range(0, 4) == 0);
            da = ($urandom_range(0, 9) == 0);
            sa = ($urandom_range(0, 11) == 0);
            lq = ($urandom_range(0, 9) == 0);
            d  = 8'($urandom);
            if ($urandom_range(0, 2) != 0) d[7] = 1'b0;
            step(rs, sw, cw, d, da, sa, lq, "R4 R5 R7 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule